// File: doc/BRIEF.md
# Profiling Record Filter Unit

This block sits at the end of a sampling profiler's capture path and gives a keep-or-discard verdict for each finished sample record. Each record arrives with a 64-bit vector of events that happened to the sampled operation, a one-hot or multi-hot operation-class vector, the total latency measured from the start of sampling, and a 16-bit data-source identifier. Static configuration inputs set which events must all be present, which events must all be absent, which operation classes are wanted and how each is matched, a minimum latency, and a data-source exclusion mask.

The verdict is registered. One cycle after a record is presented, `out_valid` rises with `out_keep` or `out_drop`. `out_drop` is a one-cycle pulse that downstream counters can use to count discarded records. Storing the record, writing it to memory and raising events are left to other blocks.

Top module: `rec_filter_top`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Back-to-back records each get their own verdict.
- R2: A record is discarded unless every bit set in `cfg_evt_need` is also set in `in_events`. Any bit position from 0 to 63 can be required.
- R3: A record is discarded if any bit set in `cfg_evt_veto` is also set in `in_events`. A veto bit that is absent from the record has no effect.
- R4: When the same event bit is set in both `cfg_evt_need` and `cfg_evt_veto`, a record carrying that event is discarded.
- R5: The `in_op` and config class bits are encoded as bit0 branch, bit1 load, bit2 store, bit3 SIMD and bit4 floating point. An enabled class whose `cfg_op_and` bit is clear is OR-matched. If any OR-matched class exists, the record must carry at least one of them.
- R6: An enabled class whose `cfg_op_and` bit is set is AND-matched, and the record must carry every such class. When both modes are in use, both conditions apply.
- R7: With no class enabled, the class test passes for every record. A `cfg_op_and` bit whose enable bit is clear has no effect.
- R8: A record with `in_latency` equal to or above `cfg_min_lat` passes the latency test. A record below it is discarded.
- R9: For a data-source ID N in 0..63, setting bit N of `cfg_src_block` discards the record. An all-zero mask discards nothing.
- R10: Data-source IDs of 64 and above are never discarded by the data-source test, whatever the mask holds.
- R11: `out_keep` and `out_drop` are only ever high together with `out_valid`, and never both at once. When `in_valid` was low, neither is high.
- R12: While `rst_n` is low, `out_valid`, `out_keep` and `out_drop` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A record is presented this cycle |
| in_events | input | 64 | Event vector of the record |
| in_op | input | 5 | Operation classes of the record |
| in_latency | input | 12 | Total latency of the record |
| in_src | input | 16 | Data-source ID of the record |
| cfg_evt_need | input | 64 | Events that must all be present |
| cfg_evt_veto | input | 64 | Events of which none may be present |
| cfg_op_en | input | 5 | Operation classes taking part in matching |
| cfg_op_and | input | 5 | Per class: 1 = AND-match, 0 = OR-match |
| cfg_min_lat | input | 12 | Minimum latency kept |
| cfg_src_block | input | 64 | Bit N discards data source N |
| out_valid | output | 1 | Verdict present |
| out_keep | output | 1 | Record is kept |
| out_drop | output | 1 | Pulse: record was discarded |

## Verification
The bench aims at the edges where each test changes its answer.

- **Latency threshold.** A record exactly at the minimum latency must be kept, and one a single count below must be dropped. A strict comparison would drop the first.
- **Data source 63 and 64.** Data source 63 is checked under an all-ones mask, and then data source 64. A design that truncates the ID to six bits would drop the second.
- **Conflicting masks and event bit 63.** The need and veto masks are set on the same bit, and event bit 63 is required on its own. This catches priority and index-width errors.
- **Class matching.** Mixed AND/OR class settings are used, together with AND bits whose enable is clear. A design that confuses the two modes, or honours a disabled AND bit, keeps or drops the wrong records.
- **Pulse behaviour.** Back-to-back and idle cycles check that `out_drop` neither stretches nor fires without a record.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // operation class bit positions in the class vectors
  localparam int unsigned OP_BRANCH = 0;
  localparam int unsigned OP_LOAD   = 1;
  localparam int unsigned OP_STORE  = 2;
  localparam int unsigned OP_SIMD   = 3;
  localparam int unsigned OP_FLOAT  = 4;
  localparam int unsigned NUM_OPS   = 5;

  typedef logic [NUM_OPS-1:0] op_vec_t;

  typedef struct packed {
    logic valid;
    logic keep;
    logic drop;
  } verdict_t;
endpackage

// File: rtl/rf_evt_match.sv
module rf_evt_match #(
  parameter int unsigned EVT_W = 64
) (
  input  logic [EVT_W-1:0] events,
  input  logic [EVT_W-1:0] need,
  input  logic [EVT_W-1:0] veto,
  output logic             pass
);
  logic need_ok;
  logic veto_hit;

  always_comb begin
    need_ok  = ((events & need) == need);
    veto_hit = |(events & veto);
    // a veto always wins over a requirement on the same bit
    pass     = need_ok && !veto_hit;
  end
endmodule

// File: rtl/rf_op_match.sv
module rf_op_match
  import rf_pkg::*;
(
  input  op_vec_t op,
  input  op_vec_t en,
  input  op_vec_t and_mode,
  output logic    pass
);
  op_vec_t and_ok;
  op_vec_t or_cand;
  op_vec_t or_hit;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    always_comb begin
      and_ok[i]  = !(en[i] && and_mode[i]) || op[i];
      or_cand[i] = en[i] && !and_mode[i];
      or_hit[i]  = or_cand[i] && op[i];
    end
  end

  always_comb begin
    pass = (&and_ok) && ((or_cand == '0) || (|or_hit));
  end
endmodule

// File: rtl/rf_lat_src_match.sv
module rf_lat_src_match #(
  parameter int unsigned LAT_W  = 12,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned MASK_W = 64
) (
  input  logic [LAT_W-1:0]  latency,
  input  logic [LAT_W-1:0]  min_lat,
  input  logic [SRC_W-1:0]  src,
  input  logic [MASK_W-1:0] block,
  output logic              pass
);
  localparam int unsigned IDX_W = $clog2(MASK_W);

  logic             lat_ok;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             src_blocked;

  always_comb begin
    lat_ok      = (latency >= min_lat);
    in_range    = (src < SRC_W'(MASK_W));
    idx         = src[IDX_W-1:0];
    src_blocked = in_range && block[idx];
    pass        = lat_ok && !src_blocked;
  end
endmodule

// File: rtl/rec_filter_top.sv
module rec_filter_top
  import rf_pkg::*;
#(
  parameter int unsigned EVT_W  = 64,
  parameter int unsigned LAT_W  = 12,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EVT_W-1:0]  in_events,
  input  logic [NUM_OPS-1:0] in_op,
  input  logic [LAT_W-1:0]  in_latency,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [EVT_W-1:0]  cfg_evt_need,
  input  logic [EVT_W-1:0]  cfg_evt_veto,
  input  logic [NUM_OPS-1:0] cfg_op_en,
  input  logic [NUM_OPS-1:0] cfg_op_and,
  input  logic [LAT_W-1:0]  cfg_min_lat,
  input  logic [MASK_W-1:0] cfg_src_block,
  output logic              out_valid,
  output logic              out_keep,
  output logic              out_drop
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic evt_pass;
  logic op_pass;
  logic ls_pass;

  rf_evt_match #(.EVT_W(EVT_W)) u_evt (
    .events (in_events),
    .need   (cfg_evt_need),
    .veto   (cfg_evt_veto),
    .pass   (evt_pass)
  );

  rf_op_match u_op (
    .op       (in_op),
    .en       (cfg_op_en),
    .and_mode (cfg_op_and),
    .pass     (op_pass)
  );

  rf_lat_src_match #(.LAT_W(LAT_W), .SRC_W(SRC_W), .MASK_W(MASK_W)) u_ls (
    .latency (in_latency),
    .min_lat (cfg_min_lat),
    .src     (in_src),
    .block   (cfg_src_block),
    .pass    (ls_pass)
  );

  verdict_t vd_d;
  verdict_t vd_q;

  always_comb begin
    vd_d.valid = in_valid;
    vd_d.keep  = in_valid && evt_pass && op_pass && ls_pass;
    vd_d.drop  = in_valid && !(evt_pass && op_pass && ls_pass);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vd_q <= '0;
    end else begin
      vd_q <= vd_d;
    end
  end

  assign out_valid = vd_q.valid;
  assign out_keep  = vd_q.keep;
  assign out_drop  = vd_q.drop;
endmodule

// File: rtl/rf_filter_chk.sv
module rf_filter_chk #(
  parameter int unsigned EVT_W  = 64,
  parameter int unsigned LAT_W  = 12,
  parameter int unsigned SRC_W  = 16,
  parameter int unsigned MASK_W = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [EVT_W-1:0]  in_events,
  input logic [LAT_W-1:0]  in_latency,
  input logic [SRC_W-1:0]  in_src,
  input logic [EVT_W-1:0]  cfg_evt_need,
  input logic [EVT_W-1:0]  cfg_evt_veto,
  input logic [LAT_W-1:0]  cfg_min_lat,
  input logic [MASK_W-1:0] cfg_src_block,
  input logic              out_valid,
  input logic              out_keep,
  input logic              out_drop
);
  localparam int unsigned IDX_W = $clog2(MASK_W);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R11
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_keep || out_drop) |-> (out_valid && (out_keep != out_drop)));

  // R2
  need_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ((in_events & cfg_evt_need) != cfg_evt_need)) |=> out_drop);

  // R3
  veto_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (|(in_events & cfg_evt_veto))) |=> out_drop);

  // R8
  lat_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_latency < cfg_min_lat)) |=> !out_keep);

  // R9
  src_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_src < SRC_W'(MASK_W)) && cfg_src_block[in_src[IDX_W-1:0]]) |=> out_drop);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && !out_drop && !out_keep));
endmodule

bind rec_filter_top rf_filter_chk #(
  .EVT_W(EVT_W), .LAT_W(LAT_W), .SRC_W(SRC_W), .MASK_W(MASK_W)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .in_valid      (in_valid),
  .in_events     (in_events),
  .in_latency    (in_latency),
  .in_src        (in_src),
  .cfg_evt_need  (cfg_evt_need),
  .cfg_evt_veto  (cfg_evt_veto),
  .cfg_min_lat   (cfg_min_lat),
  .cfg_src_block (cfg_src_block),
  .out_valid     (out_valid),
  .out_keep      (out_keep),
  .out_drop      (out_drop)
);

// File: tb/tb_rec_filter_top.sv
`timescale 1ns/1ps
module tb_rec_filter_top;
  localparam real CLK_NS = 8.0;

  typedef struct packed {
    logic [63:0] ev;
    logic [4:0]  op;
    logic [11:0] lat;
    logic [15:0] src;
    logic [63:0] need;
    logic [63:0] veto;
    logic [4:0]  en;
    logic [4:0]  andm;
    logic [11:0] minl;
    logic [63:0] blk;
    logic        keep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam logic [63:0] ONES = '1;
  localparam vec_t VECS [NV] = '{
    // R9: nothing configured, record kept
    '{64'h0, 5'h00, 12'd0, 16'd0, 64'h0, 64'h0, 5'h00, 5'h00, 12'd0, 64'h0, 1'b1, 8'd9},
    // R2: both required events (L1 refill bit3, TLB refill bit5) present
    '{64'h28, 5'h00, 12'd5, 16'd0, 64'h28, 64'h0, 5'h00, 5'h00, 12'd0, 64'h0, 1'b1, 8'd2},
    // R2: one required event missing
    '{64'h08, 5'h00, 12'd5, 16'd0, 64'h28, 64'h0, 5'h00, 5'h00, 12'd0, 64'h0, 1'b0, 8'd2},
    // R2: bit 63 required and present
    '{64'hFFFF_FFFF_FFFF_FFFF, 5'h00, 12'd5, 16'd0, 64'h8000_0000_0000_0000, 64'h0, 5'h00, 5'h00, 12'd0, 64'h0, 1'b1, 8'd2},
    // R3: one vetoed event present
    '{64'h20, 5'h00, 12'd5, 16'd0, 64'h0, 64'h28, 5'h00, 5'h00, 12'd0, 64'h0, 1'b0, 8'd3},
    // R3: vetoed events absent (retired bit1, mispredict bit7 present)
    '{64'h82, 5'h00, 12'd5, 16'd0, 64'h0, 64'h28, 5'h00, 5'h00, 12'd0, 64'h0, 1'b1, 8'd3},
    // R4: same bit in need and veto
    '{64'h80, 5'h00, 12'd5, 16'd0, 64'h80, 64'h80, 5'h00, 5'h00, 12'd0, 64'h0, 1'b0, 8'd4},
    // R5: branch|load OR, record is load
    '{64'h0, 5'h02, 12'd5, 16'd0, 64'h0, 64'h0, 5'h03, 5'h00, 12'd0, 64'h0, 1'b1, 8'd5},
    // R5: branch|load OR, record is store
    '{64'h0, 5'h04, 12'd5, 16'd0, 64'h0, 64'h0, 5'h03, 5'h00, 12'd0, 64'h0, 1'b0, 8'd5},
    // R5: only store enabled, record is store
    '{64'h0, 5'h04, 12'd5, 16'd0, 64'h0, 64'h0, 5'h04, 5'h00, 12'd0, 64'h0, 1'b1, 8'd5},
    // R6: store AND SIMD, record both
    '{64'h0, 5'h0C, 12'd5, 16'd0, 64'h0, 64'h0, 5'h0C, 5'h0C, 12'd0, 64'h0, 1'b1, 8'd6},
    // R6: store AND SIMD, record store only
    '{64'h0, 5'h04, 12'd5, 16'd0, 64'h0, 64'h0, 5'h0C, 5'h0C, 12'd0, 64'h0, 1'b0, 8'd6},
    // R6: SIMD AND, branch|load OR, record SIMD only
    '{64'h0, 5'h08, 12'd5, 16'd0, 64'h0, 64'h0, 5'h0B, 5'h08, 12'd0, 64'h0, 1'b0, 8'd6},
    // R6: SIMD AND, branch|load OR, record SIMD+load
    '{64'h0, 5'h0A, 12'd5, 16'd0, 64'h0, 64'h0, 5'h0B, 5'h08, 12'd0, 64'h0, 1'b1, 8'd6},
    // R7: AND bits without enables, no class on record
    '{64'h0, 5'h00, 12'd5, 16'd0, 64'h0, 64'h0, 5'h00, 5'h1F, 12'd0, 64'h0, 1'b1, 8'd7},
    // R8: latency equal to minimum
    '{64'h0, 5'h00, 12'd100, 16'd0, 64'h0, 64'h0, 5'h00, 5'h00, 12'd100, 64'h0, 1'b1, 8'd8},
    // R8: latency one below minimum
    '{64'h0, 5'h00, 12'd99, 16'd0, 64'h0, 64'h0, 5'h00, 5'h00, 12'd100, 64'h0, 1'b0, 8'd8},
    // R8: maximum latency
    '{64'h0, 5'h00, 12'd4095, 16'd0, 64'h0, 64'h0, 5'h00, 5'h00, 12'd100, 64'h0, 1'b1, 8'd8},
    // R9: source 9 blocked
    '{64'h0, 5'h00, 12'd5, 16'd9, 64'h0, 64'h0, 5'h00, 5'h00, 12'd0, 64'h200, 1'b0, 8'd9},
    // R9: source 8 not blocked
    '{64'h0, 5'h00, 12'd5, 16'd8, 64'h0, 64'h0, 5'h00, 5'h00, 12'd0, 64'h200, 1'b1, 8'd9},
    // R9: source 63 under all-ones mask
    '{64'h0, 5'h00, 12'd5, 16'd63, 64'h0, 64'h0, 5'h00, 5'h00, 12'd0, ONES, 1'b0, 8'd9},
    // R10: source 64 under all-ones mask bypasses
    '{64'h0, 5'h00, 12'd5, 16'd64, 64'h0, 64'h0, 5'h00, 5'h00, 12'd0, ONES, 1'b1, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_events;
  logic [4:0]  in_op;
  logic [11:0] in_latency;
  logic [15:0] in_src;
  logic [63:0] cfg_evt_need;
  logic [63:0] cfg_evt_veto;
  logic [4:0]  cfg_op_en;
  logic [4:0]  cfg_op_and;
  logic [11:0] cfg_min_lat;
  logic [63:0] cfg_src_block;
  logic        out_valid;
  logic        out_keep;
  logic        out_drop;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  rec_filter_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_events(in_events),
    .in_op(in_op), .in_latency(in_latency), .in_src(in_src),
    .cfg_evt_need(cfg_evt_need), .cfg_evt_veto(cfg_evt_veto),
    .cfg_op_en(cfg_op_en), .cfg_op_and(cfg_op_and), .cfg_min_lat(cfg_min_lat),
    .cfg_src_block(cfg_src_block), .out_valid(out_valid), .out_keep(out_keep),
    .out_drop(out_drop)
  );

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {out_valid, out_keep, out_drop};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {valid,keep,drop} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t v);
    in_events     = v.ev;
    in_op         = v.op;
    in_latency    = v.lat;
    in_src        = v.src;
    cfg_evt_need  = v.need;
    cfg_evt_veto  = v.veto;
    cfg_op_en     = v.en;
    cfg_op_and    = v.andm;
    cfg_min_lat   = v.minl;
    cfg_src_block = v.blk;
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    load_vec(VECS[0]);
    in_valid = 1'b1; // input activity during reset must not show
    repeat (3) @(negedge clk);
    check("R12 in reset", 3'b000);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 idle after reset", 3'b000);

    // table walk: present, then sample one edge later
    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {1'b1, VECS[i].keep, !VECS[i].keep});
      @(negedge clk);
      check($sformatf("R11 idle after vector %0d", i), 3'b000);
    end

    // R1: back-to-back keep, drop, keep
    load_vec(VECS[15]);
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", 3'b110);
    load_vec(VECS[16]);
    @(negedge clk);
    check("R1 b2b second drop", 3'b101);
    load_vec(VECS[15]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b third keep", 3'b110);
    @(negedge clk);
    check("R11 drop pulse not stretched", 3'b000);

    // R3: a vetoed record presented with in_valid low leaves no trace
    load_vec(VECS[4]);
    @(negedge clk);
    check("R11 invalid record ignored", 3'b000);

    // R12: asynchronous reset in the middle of a stream
    load_vec(VECS[16]);
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 before reset", 3'b101);
    #1 rst_n = 1'b0;
    #1;
    check("R12 async clear", 3'b000);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    load_vec(VECS[1]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 after reset", 3'b110);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule